// File: doc/BRIEF.md
# Phase-Two Clocked Bus Register Slave

This block is a small register slave for an 8-bit microprocessor bus that offers no clock other than the phase-two bus clock. It holds a bank of four data registers. Two address inputs select one register, and one select input stands for all the other address decoding, which is done outside the block. The data bus tristate buffer also sits outside. The block drives it through a data-out bus and an output-enable.

Reads are purely combinational. The data-out bus always shows the register at the present address. It follows an address change within the same propagation delay, even while phase two is high. Reading never alters any state, so glitching or repeated reads are harmless. A write is decided only by the select, read/write, address and data levels present at the falling edge of phase two. Whatever those lines did earlier in the high phase does not matter. This removes the hazard of a gated write strobe when read/write flips mid-cycle.

Top module: `p2_bus_regs`

## Requirements
- R1: With `rst` high at a falling edge of `phi2`, every register becomes 0x00 at that edge. Reset is synchronous to the phase-two falling edge and active high.
- R2: At a falling edge of `phi2`, if `cs`=1 and `rw`=0, the register numbered by `addr` (0 to 3) takes the value on `din`.
- R3: At a falling edge with `cs`=0, no register changes, whatever the state of `rw`, `addr` and `din`.
- R4: A read (`cs`=1, `rw`=1) changes no register. Repeated reads return the same value.
- R5: `dout` always equals the register selected by the present `addr`, independent of `phi2`, `cs` and `rw`. It follows an address change made while `phi2` is high.
- R6: `doe` is 1 exactly when `cs`=1, `phi2`=1 and `rw`=1. It is 0 during any write and whenever `phi2` is low.
- R7: If a cycle starts as a write and `rw` returns to 1 before the falling edge, no register is written.
- R8: If a cycle starts as a read and `rw` drops to 0 while `phi2` is high, `doe` goes to 0 at once. The write then lands at the falling edge, using the `addr` and `din` present at that edge.
- R9: A write changes only the addressed register. The other three keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| phi2 | input | 1 | Phase-two bus clock; registers update on its falling edge |
| rst | input | 1 | Active-high reset, sampled at the falling edge of phi2 |
| cs | input | 1 | Externally decoded chip select, active high |
| rw | input | 1 | 1 = read, 0 = write |
| addr | input | 2 | Register number |
| din | input | 8 | Write data from the bus |
| dout | output | 8 | Selected register contents, for the external buffer |
| doe | output | 1 | Enable for the external data buffer |

## Verification
The only register stage in the block is the falling edge of phi2. A write is therefore due from that edge on. The bench samples register contents 2 ns after the edge, or reads them back during a later high phase. `dout` and `doe` have no register in their path. The bench checks them within the same high phase, a few nanoseconds after each change to `addr`, `rw` or `cs`. This is how it shows that the output follows mid-cycle address changes and switches off at once on a turn to write. Each write-hazard cycle is followed by a full readback, which confirms that only the levels at the edge decided the outcome.

// File: rtl/p2_bus_pkg.sv
package p2_bus_pkg;
  localparam int unsigned SEL_W  = 2;
  localparam int unsigned WORD_W = 8;
endpackage

// File: rtl/p2_wr_decode.sv
module p2_wr_decode #(
  parameter int unsigned SEL_W = p2_bus_pkg::SEL_W,
  localparam int unsigned NREG = 1 << SEL_W
) (
  input  logic             cs,
  input  logic             rw,
  input  logic [SEL_W-1:0] addr,
  output logic [NREG-1:0]  wr_en
);
  // Level decode only; the register bank samples it at the phi2 falling edge,
  // so no strobe is ever formed from phi2 itself.
  for (genvar i = 0; i < NREG; i++) begin : g_dec
    assign wr_en[i] = cs && !rw && (addr == SEL_W'(i));
  end
endmodule

// File: rtl/p2_reg_bank.sv
module p2_reg_bank #(
  parameter int unsigned SEL_W  = p2_bus_pkg::SEL_W,
  parameter int unsigned WORD_W = p2_bus_pkg::WORD_W,
  localparam int unsigned NREG  = 1 << SEL_W
) (
  input  logic                        phi2,
  input  logic                        rst,
  input  logic [NREG-1:0]             wr_en,
  input  logic [WORD_W-1:0]           din,
  output logic [NREG-1:0][WORD_W-1:0] regs
);
  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(negedge phi2) begin
      if (rst)           regs[i] <= '0;
      else if (wr_en[i]) regs[i] <= din;
    end

    assert_write_lands_R2: assert property (@(negedge phi2) disable iff (rst)
      wr_en[i] |=> regs[i] == $past(din))
      else $error("register %0d missed its write", i);

    // Covers R3, R4 and R7: any edge without a write enable leaves the word alone.
    assert_hold_without_write_R4: assert property (@(negedge phi2) disable iff (rst)
      !wr_en[i] |=> $stable(regs[i]))
      else $error("register %0d changed without a write", i);
  end

  assert_single_target_R9: assert property (@(negedge phi2) disable iff (rst)
    $onehot0(wr_en))
    else $error("more than one register enabled for write");

  assert_reset_clears_R1: assert property (@(negedge phi2) disable iff (rst)
    $fell(rst) |-> regs == '0)
    else $error("registers not cleared by reset");
endmodule

// File: rtl/p2_rd_path.sv
module p2_rd_path #(
  parameter int unsigned SEL_W  = p2_bus_pkg::SEL_W,
  parameter int unsigned WORD_W = p2_bus_pkg::WORD_W,
  localparam int unsigned NREG  = 1 << SEL_W
) (
  input  logic                        phi2,
  input  logic                        cs,
  input  logic                        rw,
  input  logic [SEL_W-1:0]            addr,
  input  logic [NREG-1:0][WORD_W-1:0] regs,
  output logic [WORD_W-1:0]           dout,
  output logic                        doe
);
  // Side-effect free: nothing here feeds back into the register bank.
  assign dout = regs[addr];
  assign doe  = cs && phi2 && rw;
endmodule

// File: rtl/p2_bus_regs.sv
module p2_bus_regs #(
  parameter int unsigned SEL_W  = p2_bus_pkg::SEL_W,
  parameter int unsigned WORD_W = p2_bus_pkg::WORD_W
) (
  input  logic              phi2,
  input  logic              rst,
  input  logic              cs,
  input  logic              rw,
  input  logic [SEL_W-1:0]  addr,
  input  logic [WORD_W-1:0] din,
  output logic [WORD_W-1:0] dout,
  output logic              doe
);
  localparam int unsigned NREG = 1 << SEL_W;

  logic [NREG-1:0]             wr_en;
  logic [NREG-1:0][WORD_W-1:0] regs;

  p2_wr_decode #(.SEL_W(SEL_W)) u_dec (
    .cs(cs), .rw(rw), .addr(addr), .wr_en(wr_en)
  );

  p2_reg_bank #(.SEL_W(SEL_W), .WORD_W(WORD_W)) u_bank (
    .phi2(phi2), .rst(rst), .wr_en(wr_en), .din(din), .regs(regs)
  );

  p2_rd_path #(.SEL_W(SEL_W), .WORD_W(WORD_W)) u_rd (
    .phi2(phi2), .cs(cs), .rw(rw), .addr(addr), .regs(regs),
    .dout(dout), .doe(doe)
  );
endmodule

// File: tb/p2_bus_regs_tb.sv
module p2_bus_regs_tb_top;
  logic       phi2 = 1'b0;
  logic       rst  = 1'b1;
  logic       cs   = 1'b0;
  logic       rw   = 1'b1;
  logic [1:0] addr = '0;
  logic [7:0] din  = '0;
  logic [7:0] dout;
  logic       doe;

  int n_checks = 0;
  int n_fail   = 0;
  logic [7:0] model [4];

  always #10 phi2 = ~phi2;  // 50 MHz

  p2_bus_regs dut_i (
    .phi2(phi2), .rst(rst), .cs(cs), .rw(rw),
    .addr(addr), .din(din), .dout(dout), .doe(doe)
  );

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Read every register back during one cycle each and compare with the model.
  task automatic readback(input string tag);
    for (int a = 0; a < 4; a++) begin
      @(posedge phi2); #2;
      cs = 1'b1; rw = 1'b1; addr = 2'(a);
      #3 check(dout, model[a], tag);
      check({7'd0, doe}, 8'd1, "R6 doe during read");
      @(negedge phi2); #2;
      check({7'd0, doe}, 8'd0, "R6 doe with phi2 low");
      cs = 1'b0;
    end
  endtask

  task automatic write_reg(input logic [1:0] a, input logic [7:0] d);
    @(posedge phi2); #2;
    cs = 1'b1; rw = 1'b0; addr = a; din = d;
    #3 check({7'd0, doe}, 8'd0, "R6 doe during write");
    @(negedge phi2); #2;
    cs = 1'b0; rw = 1'b1;
    model[a] = d;
  endtask

  task automatic t_reset;
    write_reg(2'd0, 8'h5A);
    write_reg(2'd3, 8'hC3);
    rst = 1'b1;
    @(negedge phi2); #2;
    rst = 1'b0;
    for (int a = 0; a < 4; a++) model[a] = 8'h00;
    readback("R1 reset clears");
  endtask

  task automatic t_writes;
    write_reg(2'd0, 8'h11);
    write_reg(2'd1, 8'h22);
    write_reg(2'd2, 8'h33);
    write_reg(2'd3, 8'h44);
    readback("R2 write all four");
    write_reg(2'd2, 8'hA5);
    readback("R9 single register write");
  endtask

  task automatic t_deselect;
    @(posedge phi2); #2;
    cs = 1'b0; rw = 1'b0; addr = 2'd1; din = 8'hEE;
    #3 check({7'd0, doe}, 8'd0, "R6 doe deselected");
    @(negedge phi2); #2;
    rw = 1'b1;
    readback("R3 deselected write ignored");
  endtask

  task automatic t_read_moves;
    @(posedge phi2); #2;
    cs = 1'b1; rw = 1'b1; addr = 2'd0;
    #2 check(dout, model[0], "R5 dout before move");
    addr = 2'd3;
    #2 check(dout, model[3], "R5 dout follows address");
    addr = 2'd1;
    #2 check(dout, model[1], "R5 dout follows again");
    @(negedge phi2); #2;
    check(dout, model[1], "R5 dout with phi2 low");
    cs = 1'b0;
    readback("R4 reads leave registers");
    readback("R4 repeated reads");
  endtask

  task automatic t_read_to_write;
    @(posedge phi2); #2;
    cs = 1'b1; rw = 1'b1; addr = 2'd1;
    #2 check({7'd0, doe}, 8'd1, "R8 doe during read part");
    rw = 1'b0; addr = 2'd3; din = 8'h7E;
    #1 check({7'd0, doe}, 8'd0, "R8 doe off on turn to write");
    @(negedge phi2); #2;
    cs = 1'b0; rw = 1'b1;
    model[3] = 8'h7E;
    readback("R8 write lands at edge");
  endtask

  task automatic t_write_to_read;
    @(posedge phi2); #2;
    cs = 1'b1; rw = 1'b0; addr = 2'd2; din = 8'h99;
    #3 rw = 1'b1;
    #2 check({7'd0, doe}, 8'd1, "R6 doe after turn to read");
    @(negedge phi2); #2;
    cs = 1'b0;
    readback("R7 aborted write");
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    for (int a = 0; a < 4; a++) model[a] = 8'h00;
    repeat (2) @(negedge phi2);
    #2 rst = 1'b0;
    check({7'd0, doe}, 8'd0, "R6 doe idle after reset");
    readback("R1 reset state");
    t_writes;
    t_deselect;
    t_read_moves;
    t_read_to_write;
    t_write_to_read;
    t_reset;
    finish_run;
  end

  initial begin
    #200000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run;
  end
endmodule